// File: doc/BRIEF.md
# Far-End Alarm Code Receiver with Dual-Clock Queue

This block watches a serial stream of far-end alarm and control codes on the line side. It finds framed 6-bit codes and keeps those that are confirmed. Each confirmed code goes into a four-entry queue, written on the line clock. Software removes entries on a separate register clock and sees empty, full and a sticky overflow flag.

The two sides share no clock. The queue pointers cross between domains in Gray code through two-stage synchronisers. Either side can therefore keep working while the other side's clock is stopped. A line bit-enable marks which line clock cycles carry a valid stream bit, so the stream can run at a fraction of the line clock rate.

Top module: `farend_code_rx`

## Requirements
- R1: A code is detected when the last 16 enabled bits, in order of arrival, are a 0, six data bits d1..d6, a 0 and then eight 1s. The stored value has d1 (the first data bit received) in bit 0 and d6 in bit 5.
- R2: Line cycles with `lineBitEn` low do not shift the stream. A frame presented entirely with `lineBitEn` low stores nothing, and disabled bits placed between the bits of a frame do not stop it from being detected.
- R3: A code enters the queue only when the detection before it carried the same value. A single isolated detection stores nothing.
- R4: A run of consecutive detections of one value stores it once. A different value starts a new run. Going back to an earlier value after a different one again needs two detections.
- R5: The queue holds four codes and returns them in arrival order. After four stores with no reads, `regFull` is 1. With no stored codes, `regEmpty` is 1.
- R6: A code confirmed while the queue is full is dropped, and the four held codes stay unchanged and in order.
- R7: A dropped code sets `regOvf`. It stays set, even across reads, until a one-cycle pulse on `regClrOvf` clears it.
- R8: A read strobe while the queue is empty makes `regData` 0 on the next register clock edge. It does not move the read position, so the next stored code still reads back correctly.
- R9: After reset, `regEmpty`=1, `regFull`=0, `regOvf`=0 and `regData`=0.
- R10: Codes received while the register clock is stopped can be read once it runs again. Stored codes can be read while the line clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lineClk | input | 1 | Line side clock |
| lineRstN | input | 1 | Line side reset, active low |
| lineBitEn | input | 1 | High when `lineBit` carries a stream bit this cycle |
| lineBit | input | 1 | Serial stream bit |
| regClk | input | 1 | Register side clock |
| regRstN | input | 1 | Register side reset, active low |
| regRd | input | 1 | Read strobe, one cycle per entry |
| regClrOvf | input | 1 | Clears the overflow flag |
| regData | output | 6 | Code from the last read, 0 after a read of an empty queue |
| regEmpty | output | 1 | No codes held |
| regFull | output | 1 | Four codes held |
| regOvf | output | 1 | Sticky flag: a confirmed code was dropped |

## Verification
The hardest state to reach is a confirmed code arriving while the queue is full. Reaching it takes four distinct runs of at least two frames each, with no read between them, followed by a fifth run. Only after that can the bench check that the held entries are intact and that the flag survives reads. The stimulus builds this directly. Random runs with noise bits, disabled-bit gaps and irregular reads then drive the queue into full and empty states many times. The bench also stops each clock in turn to show that the pointer crossing works when only one side is running.

// File: rtl/farend_code_pkg.sv
package farend_code_pkg;
  localparam int CODE_W = 6;

  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
  } lineStb_t;

  typedef struct packed {
    logic pop;
    logic zeroRd;
    logic clrOvf;
  } regStb_t;
endpackage

// File: rtl/farend_code_sync.sv
module farend_code_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= '0;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/farend_code_ctrl.sv
module farend_code_ctrl
  import farend_code_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic     lineClk,
  input  logic     lineRstN,
  input  logic     lineBitEn,
  input  logic     lineBit,
  input  logic     regRd,
  input  logic     regClrOvf,
  input  logic     regEmpty,
  output lineStb_t lineStb,
  output regStb_t  regStb
);
  localparam int FRAME_W = CODE_W + FLAG_W + 2;

  logic [FRAME_W-1:0] shiftQ, shiftNext;
  logic [CODE_W-1:0]  rxCode, lastCode;
  logic               haveLast, runStored, match, sameAsLast, qualify;

  assign shiftNext = lineBitEn ? {shiftQ[FRAME_W-2:0], lineBit} : shiftQ;
  assign match = lineBitEn && !shiftNext[FRAME_W-1] && !shiftNext[FLAG_W]
               && (&shiftNext[FLAG_W-1:0]);

  // first data bit received lands in bit 0
  for (genvar i = 0; i < CODE_W; i++) begin : g_bitMap
    assign rxCode[i] = shiftNext[FRAME_W-2-i];
  end

  assign sameAsLast = haveLast && (rxCode == lastCode);
  assign qualify    = match && sameAsLast && !runStored;

  always_ff @(posedge lineClk or negedge lineRstN) begin
    if (!lineRstN) begin
      shiftQ       <= '0;
      lastCode     <= '0;
      haveLast     <= 1'b0;
      runStored    <= 1'b0;
      lineStb.push <= 1'b0;
      lineStb.code <= '0;
    end else begin
      shiftQ       <= shiftNext;
      lineStb.push <= qualify;
      if (match) begin
        lineStb.code <= rxCode;
        if (sameAsLast) begin
          runStored <= 1'b1;
        end else begin
          lastCode  <= rxCode;
          haveLast  <= 1'b1;
          runStored <= 1'b0;
        end
      end
    end
  end

  assign regStb.pop    = regRd && !regEmpty;
  assign regStb.zeroRd = regRd && regEmpty;
  assign regStb.clrOvf = regClrOvf;

  // R3: frames cannot overlap by one bit, so pushes are never adjacent
  a_r3_push_spacing: assert property (@(posedge lineClk) disable iff (!lineRstN)
    lineStb.push |=> !lineStb.push);

  // R4: a store marks its run as done and carries the run's value
  a_r4_run_marked: assert property (@(posedge lineClk) disable iff (!lineRstN)
    lineStb.push |-> (runStored && lastCode == lineStb.code));
endmodule

// File: rtl/farend_code_fifo.sv
module farend_code_fifo
  import farend_code_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              lineClk,
  input  logic              lineRstN,
  input  lineStb_t          lineStb,
  input  logic              regClk,
  input  logic              regRstN,
  input  regStb_t           regStb,
  output logic [CODE_W-1:0] regData,
  output logic              regEmpty,
  output logic              regFull
  ,output logic             regOvf
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fullMate(input logic [PTR_W-1:0] g);
    return {~g[PTR_W-1:PTR_W-2], g[PTR_W-3:0]};
  endfunction

  logic [CODE_W-1:0] mem [DEPTH];

  // line domain
  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync;
  logic             lineFull, ovfToggle;

  assign lineFull = (wrGray == fullMate(rdGraySync));

  always_ff @(posedge lineClk or negedge lineRstN) begin
    if (!lineRstN) begin
      wrBin     <= '0;
      wrGray    <= '0;
      ovfToggle <= 1'b0;
    end else if (lineStb.push) begin
      if (!lineFull) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end else begin
        ovfToggle <= ~ovfToggle;
      end
    end
  end

  always_ff @(posedge lineClk) begin
    if (lineStb.push && !lineFull) mem[wrBin[ADDR_W-1:0]] <= lineStb.code;
  end

  farend_code_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_rdSync (
    .clk(lineClk), .rstN(lineRstN), .d(rdGray), .q(rdGraySync));

  // register domain
  logic [PTR_W-1:0] rdBin, rdGray, wrGraySync;
  logic             ovfSync, ovfSeen, ovfSticky;

  farend_code_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_wrSync (
    .clk(regClk), .rstN(regRstN), .d(wrGray), .q(wrGraySync));

  farend_code_sync #(.W(1), .STAGES(SYNC_N)) u_ovfSync (
    .clk(regClk), .rstN(regRstN), .d(ovfToggle), .q(ovfSync));

  assign regEmpty = (rdGray == wrGraySync);
  assign regFull  = (wrGraySync == fullMate(rdGray));
  assign regOvf   = ovfSticky;

  always_ff @(posedge regClk or negedge regRstN) begin
    if (!regRstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      regData   <= '0;
      ovfSeen   <= 1'b0;
      ovfSticky <= 1'b0;
    end else begin
      ovfSeen <= ovfSync;
      if (ovfSync ^ ovfSeen)  ovfSticky <= 1'b1;
      else if (regStb.clrOvf) ovfSticky <= 1'b0;
      if (regStb.pop) begin
        regData <= mem[rdBin[ADDR_W-1:0]];
        rdBin   <= rdBin + 1'b1;
        rdGray  <= toGray(rdBin + 1'b1);
      end else if (regStb.zeroRd) begin
        regData <= '0;
      end
    end
  end

  // R5: crossing pointers move one Gray bit at a time
  a_r5_wr_gray_step: assert property (@(posedge lineClk) disable iff (!lineRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  a_r5_rd_gray_step: assert property (@(posedge regClk) disable iff (!regRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  a_r5_flags_exclusive: assert property (@(posedge regClk) disable iff (!regRstN)
    !(regEmpty && regFull));
  // R6: a drop leaves the write pointer where it was
  a_r6_full_drop: assert property (@(posedge lineClk) disable iff (!lineRstN)
    (lineStb.push && lineFull) |=> $stable(wrGray));
  // R7: overflow holds until cleared
  a_r7_ovf_sticky: assert property (@(posedge regClk) disable iff (!regRstN)
    (regOvf && !regStb.clrOvf) |=> regOvf);
  // R8: an empty read yields zero and keeps the read pointer
  a_r8_empty_ptr: assert property (@(posedge regClk) disable iff (!regRstN)
    regStb.zeroRd |=> $stable(rdGray));
  a_r8_empty_zero: assert property (@(posedge regClk) disable iff (!regRstN)
    regStb.zeroRd |=> (regData == '0));
endmodule

// File: rtl/farend_code_rx.sv
module farend_code_rx
  import farend_code_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int FLAG_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              lineClk,
  input  logic              lineRstN,
  input  logic              lineBitEn,
  input  logic              lineBit,
  input  logic              regClk,
  input  logic              regRstN,
  input  logic              regRd,
  input  logic              regClrOvf,
  output logic [CODE_W-1:0] regData,
  output logic              regEmpty,
  output logic              regFull,
  output logic              regOvf
);
  lineStb_t lineStb;
  regStb_t  regStb;

  farend_code_ctrl #(.FLAG_W(FLAG_W)) u_ctrl (
    .lineClk(lineClk), .lineRstN(lineRstN), .lineBitEn(lineBitEn),
    .lineBit(lineBit), .regRd(regRd), .regClrOvf(regClrOvf),
    .regEmpty(regEmpty), .lineStb(lineStb), .regStb(regStb));

  farend_code_fifo #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_fifo (
    .lineClk(lineClk), .lineRstN(lineRstN), .lineStb(lineStb),
    .regClk(regClk), .regRstN(regRstN), .regStb(regStb),
    .regData(regData), .regEmpty(regEmpty), .regFull(regFull),
    .regOvf(regOvf));
endmodule

// File: tb/farend_code_rx_tb.sv
`timescale 1ns/1ps
module farend_code_rx_tb;
  localparam int DEPTH = 4;

  logic lineClk = 0, regClk = 0;
  logic lineRun = 1, regRun = 1;
  logic lineRstN = 0, regRstN = 0;
  logic lineBitEn = 0, lineBit = 0, regRd = 0, regClrOvf = 0;
  logic [5:0] regData;
  logic regEmpty, regFull, regOvf;

  int checks = 0, failures = 0;

  // model state
  logic [15:0] mWin = '0;
  logic [5:0]  mLast = '0;
  logic        mHave = 0, mStored = 0, mOvf = 0;
  logic [5:0]  mq [$];

  always #10   lineClk = lineRun ? ~lineClk : 1'b0;
  always #13.5 regClk  = regRun  ? ~regClk  : 1'b0;

  farend_code_rx u_dut (
    .lineClk(lineClk), .lineRstN(lineRstN), .lineBitEn(lineBitEn),
    .lineBit(lineBit), .regClk(regClk), .regRstN(regRstN), .regRd(regRd),
    .regClrOvf(regClrOvf), .regData(regData), .regEmpty(regEmpty),
    .regFull(regFull), .regOvf(regOvf));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic isFrame(input logic [15:0] w);
    return !w[15] && !w[8] && (&w[7:0]);
  endfunction

  function automatic logic [5:0] frameCode(input logic [15:0] w);
    logic [5:0] c;
    for (int i = 0; i < 6; i++) c[i] = w[14-i];
    return c;
  endfunction

  function automatic logic [15:0] buildFrame(input logic [5:0] c);
    logic [15:0] f = 16'h00FF;
    for (int i = 0; i < 6; i++) f[14-i] = c[i];
    return f;
  endfunction

  task automatic modelDetect(input logic [5:0] c);
    if (mHave && c == mLast) begin
      if (!mStored) begin
        mStored = 1;
        if (mq.size() < DEPTH) mq.push_back(c);
        else mOvf = 1;
      end
    end else begin
      mLast = c; mHave = 1; mStored = 0;
    end
  endtask

  task automatic lineBitTask(input logic b, input logic en);
    @(negedge lineClk);
    lineBit = b; lineBitEn = en;
    if (en) begin
      mWin = {mWin[14:0], b};
      if (isFrame(mWin)) modelDetect(frameCode(mWin));
    end
  endtask

  task automatic sendFrame(input logic [15:0] f, input int gap, input logic en);
    for (int i = 15; i >= 0; i--) begin
      if (gap > 0) repeat ($urandom % (gap + 1)) lineBitTask(1'($urandom % 2), 1'b0);
      lineBitTask(f[i], en);
    end
    lineBitTask(1'b0, 1'b0);
  endtask

  task automatic sendCode(input logic [5:0] c, input int times, input int gap);
    repeat (times) sendFrame(buildFrame(c), gap, 1'b1);
  endtask

  task automatic settle();
    if (lineRun) repeat (6) lineBitTask(1'b0, 1'b0);
    repeat (6) @(negedge regClk);
  endtask

  task automatic readCheck(input string req);
    logic [5:0] exp;
    exp = (mq.size() > 0) ? mq.pop_front() : 6'h00;
    @(negedge regClk); regRd = 1;
    @(negedge regClk); regRd = 0;
    check(regData == exp, req, regData, exp);
  endtask

  task automatic statusCheck(input string req);
    settle();
    check(regEmpty == (mq.size() == 0), {req, " empty"}, regEmpty, mq.size() == 0);
    check(regFull == (mq.size() == DEPTH), {req, " full"}, regFull, mq.size() == DEPTH);
    check(regOvf == mOvf, {req, " ovf"}, regOvf, mOvf);
  endtask

  task automatic clearOvf();
    @(negedge regClk); regClrOvf = 1;
    @(negedge regClk); regClrOvf = 0;
    mOvf = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0DE57));
    repeat (4) @(negedge lineClk);
    lineRstN = 1; regRstN = 1;
    @(negedge regClk);
    // R9 reset state
    check(regEmpty == 1, "R9 empty", regEmpty, 1);
    check(regFull == 0, "R9 full", regFull, 0);
    check(regOvf == 0, "R9 ovf", regOvf, 0);
    check(regData == 0, "R9 data", regData, 0);

    // R3 single detection stores nothing
    sendCode(6'h15, 1, 0);
    statusCheck("R3 single");

    // R1 bit order: d1=1,d2=1, rest 0 -> stored 6'h03
    sendFrame(16'b0110000011111111, 0, 1'b1);
    sendFrame(16'b0110000011111111, 0, 1'b1);
    settle();
    check(mq.size() == 1 && mq[0] == 6'h03, "R1 model", mq.size(), 1);
    readCheck("R1 bit order");

    // R4 runs
    sendCode(6'h2A, 4, 0);
    statusCheck("R4 run once");
    readCheck("R4 run value");
    sendCode(6'h11, 1, 0);
    sendCode(6'h2A, 1, 0);
    statusCheck("R4 return needs two");
    sendCode(6'h2A, 1, 0);
    settle();
    readCheck("R4 return stored");

    // R8 empty read
    readCheck("R8 empty zero");
    statusCheck("R8 empty after");
    sendCode(6'h07, 2, 0);
    settle();
    readCheck("R8 pointer kept");

    // R2 disabled bits
    sendCode(6'h19, 2, 3);
    settle();
    readCheck("R2 gaps");
    repeat (3) sendFrame(buildFrame(6'h0C), 0, 1'b0);
    statusCheck("R2 disabled frame");

    // R5 / R6 fill and overflow
    sendCode(6'h01, 2, 0);
    sendCode(6'h02, 2, 0);
    sendCode(6'h04, 2, 0);
    sendCode(6'h08, 2, 0);
    statusCheck("R5 full");
    sendCode(6'h20, 2, 0);
    statusCheck("R6 overflow");
    for (int k = 0; k < DEPTH; k++) readCheck("R5 R6 order");
    statusCheck("R7 ovf survives reads");
    readCheck("R5 empty zero");
    clearOvf();
    statusCheck("R7 cleared");

    // R10 register clock stopped while codes arrive
    regRun = 0;
    sendCode(6'h31, 2, 0);
    sendCode(6'h0E, 2, 0);
    repeat (6) lineBitTask(1'b0, 1'b0);
    regRun = 1;
    statusCheck("R10 reg resume");
    readCheck("R10 reg resume");
    // line clock stopped while reading
    settle();
    lineRun = 0;
    #100;
    readCheck("R10 line stopped");
    statusCheck("R10 line stopped");
    readCheck("R10 line stopped empty");
    lineRun = 1;
    #100;

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [5:0] c;
      c = 6'($urandom);
      sendCode(c, 1 + ($urandom % 3), $urandom % 3);
      repeat ($urandom % 4) lineBitTask(1'($urandom % 2), 1'($urandom % 2));
      if ($urandom % 3 == 0) begin
        settle();
        repeat (1 + $urandom % 2) readCheck("R5 random read");
      end
      if (it % 8 == 7) begin
        statusCheck("R6 R7 random status");
        if (mOvf) clearOvf();
      end
    end
    statusCheck("R5 final");
    while (mq.size() > 0) readCheck("R5 drain");
    readCheck("R8 final empty");

    summary();
    $finish;
  end
endmodule